// File: doc/BRIEF.md
# Clock-Independent Power-State Status Register

This block is a single control and status register that a host can read and write while the main system clock is stopped. It runs on the host interface clock, which keeps running. Reads are combinational from the register state and the live inputs. Writes land on one host clock edge. Nothing passes through a staging register, and nothing in the block is clocked by the system clock.

The register has several kinds of bits:

- **Pure status.** A live copy of the link-power request line.
- **Clock-idle bit.** It shows that the system clock has stopped. With its enable off, it is plain status. With its enable on, it becomes a latched interrupt.
- **Sticky event bits.** There are `NUM_EVT` of them. They latch external event levels and are cleared by writing 1.
- **Enables.** There is one control bit per interrupt source.

A single interrupt output is the OR of every latched bit gated by its enable.

Bit layout:

| Bits | Contents |
|------|----------|
| 0 | Power line |
| 1 | Clock-idle bit |
| 2 .. 1+`NUM_EVT` | Event bits |
| 8 | Clock-idle enable |
| 9 .. 8+`NUM_EVT` | Event enables, in the same order as the event bits |

Every write rewrites all enable bits from the written data.

Top module: `pwr_state_csr`

## Requirements
- R1: Read bit 0 always equals the `lps_line` input. Writes have no effect on it.
- R2: With the clock-idle enable (bit 8) at 0, read bit 1 is 0 while `sys_clk` is toggling. It is 1 once `sys_clk` has shown no edge for `IDLE_LIMIT` host cycles. It drops back to 0 when `sys_clk` resumes. Writes to bit 1 are ignored.
- R3: With bit 8 at 1, read bit 1 latches when the clock goes idle and stays 1 after `sys_clk` resumes. While bit 1 is set, `irq` is 1. Writing 1 to bit 1 clears it once the clock is running.
- R4: A high level on `evt_in[i]` at a host clock edge sets read bit 2+i. The bit stays set whatever the value of its enable.
- R5: Writing 1 to bit 2+i clears that event bit. Writing 0 there leaves it unchanged.
- R6: If an event and a write-1 clear of the same bit arrive on the same edge, the bit stays set.
- R7: `irq` is 1 exactly when some latched bit has its enable (bit 8+k) set. Latched bits whose enables are 0 do not raise `irq`.
- R8: Bits 8 to 8+`NUM_EVT` read back the last written value. All unused bits read 0.
- R9: After reset, all enables and event bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Host interface clock, always running |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one host cycle |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data |
| sys_clk | input | 1 | Monitored system clock, may stop |
| lps_line | input | 1 | Link-power request line |
| evt_in | input | NUM_EVT | Event level inputs |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `sys_clk` runs at no more than half the host clock rate, so that each of its edges survives the synchronizer. They also assume that event levels are held for at least one host clock edge. The bench runs `sys_clk` at a quarter of the host rate, with edges offset from host edges. It drives events and writes on host falling edges for whole cycles, and it waits several `IDLE_LIMIT` windows before it samples the clock-idle bit.

// File: rtl/pwr_state_pkg.sv
// Package: bit positions and sizing shared by the power-state register.
// Assumes DATA_W is large enough to hold the enable field.
package pwr_state_pkg;
    localparam int BIT_LPS = 0;  // live power-line mirror
    localparam int BIT_CIDLE = 1;  // clock-idle status / interrupt
    localparam int EVT_LSB = 2;  // first sticky event bit
    localparam int EN_LSB = 8;  // clock-idle enable; event enables follow
endpackage

// File: rtl/clk_activity_mon.sv
// Module: detects whether a monitored clock is toggling, using only the
// host clock. Assumes the monitored clock runs at most at half the host rate.
// idle is asserted after LIMIT host cycles with no observed edge.
module clk_activity_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int LIMIT = 8
) (
    input  logic hclk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic idle
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [SYNC_STAGES:0] sync_q;
    logic [CW-1:0] gap_cnt;
    logic edge_seen;

    // Synchronizer chain plus one stage for edge detection.
    always_ff @(posedge hclk) begin
        if (!rst_n) sync_q <= '0;
        else sync_q <= {sync_q[SYNC_STAGES-1:0], mon_clk};
    end

    assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    // Count host cycles since the last edge, saturating at LIMIT.
    always_ff @(posedge hclk) begin
        if (!rst_n) gap_cnt <= CW'(LIMIT);
        else if (edge_seen) gap_cnt <= '0;
        else if (gap_cnt != CW'(LIMIT)) gap_cnt <= gap_cnt + 1'b1;
    end

    assign idle = (gap_cnt == CW'(LIMIT));

    AST_EDGE_CLEARS_IDLE: assert property (@(posedge hclk) disable iff (!rst_n)
        edge_seen |=> !idle); // R2
endmodule

// File: rtl/w1c_sticky_bit.sv
// Module: one sticky event bit. A set level latches it. A write-1 clears it.
// Set wins over clear on the same edge. Assumes the set level is held
// across a host clock edge.
module w1c_sticky_bit (
    input  logic hclk,
    input  logic rst_n,
    input  logic set_lvl,
    input  logic clr_req,
    output logic q
);
    // Hold, set or clear the latched event.
    always_ff @(posedge hclk) begin
        if (!rst_n) q <= 1'b0;
        else q <= set_lvl | (q & ~clr_req);
    end

    AST_EVT_STICKY: assert property (@(posedge hclk) disable iff (!rst_n)
        (q && !clr_req) |=> q); // R4
    AST_W1C_CLEARS: assert property (@(posedge hclk) disable iff (!rst_n)
        (clr_req && !set_lvl) |=> !q); // R5
    AST_EVT_WINS: assert property (@(posedge hclk) disable iff (!rst_n)
        set_lvl |=> q); // R6
endmodule

// File: rtl/pwr_state_csr.sv
// Module: top of the clock-independent power-state register. All state is
// on hclk; sys_clk is only observed. Reads are combinational. Every write
// reloads the whole enable field from wr_data.
module pwr_state_csr
    import pwr_state_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_EVT = 3,
    parameter int IDLE_LIMIT = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic hclk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic sys_clk,
    input  logic lps_line,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic irq
);
    localparam int EVT_EN_LSB = EN_LSB + 1;

    logic clk_idle;
    logic cidle_en;
    logic cidle_q;
    logic cidle_clr;
    logic [NUM_EVT-1:0] evt_en;
    logic [NUM_EVT-1:0] evt_q;

    clk_activity_mon #(
        .SYNC_STAGES(SYNC_STAGES),
        .LIMIT(IDLE_LIMIT)
    ) u_mon (
        .hclk(hclk),
        .rst_n(rst_n),
        .mon_clk(sys_clk),
        .idle(clk_idle)
    );

    // One sticky cell per event input.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        w1c_sticky_bit u_bit (
            .hclk(hclk),
            .rst_n(rst_n),
            .set_lvl(evt_in[i]),
            .clr_req(wr_en & wr_data[EVT_LSB+i]),
            .q(evt_q[i])
        );
    end

    // Enable field: reloaded on every write.
    always_ff @(posedge hclk) begin
        if (!rst_n) begin
            cidle_en <= 1'b0;
            evt_en <= '0;
        end else if (wr_en) begin
            cidle_en <= wr_data[EN_LSB];
            evt_en <= wr_data[EVT_EN_LSB +: NUM_EVT];
        end
    end

    assign cidle_clr = wr_en & wr_data[BIT_CIDLE];

    // Clock-idle latch: active only while its enable is set.
    always_ff @(posedge hclk) begin
        if (!rst_n) cidle_q <= 1'b0;
        else if (!cidle_en) cidle_q <= 1'b0;
        else cidle_q <= clk_idle | (cidle_q & ~cidle_clr);
    end

    // Assemble read data from live lines and state.
    always_comb begin
        rd_data = '0;
        rd_data[BIT_LPS] = lps_line;
        rd_data[BIT_CIDLE] = cidle_en ? cidle_q : clk_idle;
        rd_data[EVT_LSB +: NUM_EVT] = evt_q;
        rd_data[EN_LSB] = cidle_en;
        rd_data[EVT_EN_LSB +: NUM_EVT] = evt_en;
    end

    // Combined interrupt.
    assign irq = (cidle_en & cidle_q) | (|(evt_q & evt_en));

    AST_SCI_HOLD: assert property (@(posedge hclk) disable iff (!rst_n)
        (cidle_en && cidle_q && !cidle_clr && !(wr_en && !wr_data[EN_LSB])) |=> cidle_q); // R3
    AST_NO_EN_NO_IRQ: assert property (@(posedge hclk) disable iff (!rst_n)
        (!cidle_en && evt_en == '0) |-> !irq); // R7
    AST_LPS_MIRROR: assert property (@(posedge hclk) disable iff (!rst_n)
        rd_data[BIT_LPS] == lps_line); // R1
endmodule

// File: tb/pwr_state_csr_tb.sv
module pwr_state_csr_tb;
    localparam int DW = 16;
    localparam int NE = 3;

    logic hclk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic sys_clk = 1'b0;
    logic sclk_run = 1'b1;
    logic lps_line = 1'b0;
    logic [NE-1:0] evt_in = '0;
    logic irq;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    pwr_state_csr #(.DATA_W(DW), .NUM_EVT(NE)) u_dut (
        .hclk(hclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sys_clk(sys_clk), .lps_line(lps_line),
        .evt_in(evt_in), .irq(irq)
    );

    always #5 hclk = ~hclk;
    always #20 if (sclk_run) sys_clk = ~sys_clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge hclk);
    endtask

    task automatic write_reg(input logic [DW-1:0] d);
        @(negedge hclk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge hclk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic pulse_evt(input int idx);
        @(negedge hclk);
        evt_in[idx] = 1'b1;
        @(negedge hclk);
        evt_in[idx] = 1'b0;
    endtask

    task automatic t_reset;
        wait_cyc(1);
        check("R9 bits", 32'(rd_data & 16'hFFFC), 32'h0);
        check("R9 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_lps;
        lps_line = 1'b1; #1;
        check("R1 high", 32'(rd_data[0]), 32'h1);
        write_reg(16'h0000); #1;
        check("R1 write0", 32'(rd_data[0]), 32'h1);
        lps_line = 1'b0; #1;
        check("R1 low", 32'(rd_data[0]), 32'h0);
        write_reg(16'h0001); #1;
        check("R1 write1", 32'(rd_data[0]), 32'h0);
    endtask

    task automatic t_sci_status;
        write_reg(16'h0000);
        wait_cyc(10);
        check("R2 running", 32'(rd_data[1]), 32'h0);
        sclk_run = 1'b0;
        wait_cyc(30);
        check("R2 stopped", 32'(rd_data[1]), 32'h1);
        check("R7 sci disabled irq", 32'(irq), 32'h0);
        write_reg(16'h0002);
        check("R2 write ignored", 32'(rd_data[1]), 32'h1);
        sclk_run = 1'b1;
        wait_cyc(10);
        check("R2 resumed", 32'(rd_data[1]), 32'h0);
    endtask

    task automatic t_sci_irq;
        write_reg(16'h0100);
        wait_cyc(10);
        check("R3 armed clear", 32'(rd_data[1]), 32'h0);
        check("R3 armed irq", 32'(irq), 32'h0);
        sclk_run = 1'b0;
        wait_cyc(30);
        check("R3 latched", 32'(rd_data[1]), 32'h1);
        check("R3 irq", 32'(irq), 32'h1);
        sclk_run = 1'b1;
        wait_cyc(10);
        check("R3 held after resume", 32'(rd_data[1]), 32'h1);
        write_reg(16'h0102);
        check("R3 ack clear", 32'(rd_data[1]), 32'h0);
        check("R3 ack irq", 32'(irq), 32'h0);
        write_reg(16'h0000);
    endtask

    task automatic t_events;
        pulse_evt(0);
        check("R4 set disabled", 32'(rd_data[2]), 32'h1);
        check("R7 masked", 32'(irq), 32'h0);
        write_reg(16'h0200);
        check("R7 enabled irq", 32'(irq), 32'h1);
        check("R5 write0 keeps", 32'(rd_data[2]), 32'h1);
        write_reg(16'h0204);
        check("R5 w1c clear", 32'(rd_data[2]), 32'h0);
        check("R7 irq drops", 32'(irq), 32'h0);
        pulse_evt(2);
        pulse_evt(1);
        check("R4 two events", 32'(rd_data[4:2]), 32'h6);
        check("R7 other masked", 32'(irq), 32'h0);
        write_reg(16'h0800);
        check("R7 evt2 irq", 32'(irq), 32'h1);
        write_reg(16'h0010);
        check("R5 clear one", 32'(rd_data[4:2]), 32'h2);
        check("R7 none", 32'(irq), 32'h0);
    endtask

    task automatic t_coincide;
        @(negedge hclk);
        evt_in[1] = 1'b1;
        wr_en = 1'b1;
        wr_data = 16'h0008;
        @(negedge hclk);
        evt_in[1] = 1'b0;
        wr_en = 1'b0;
        wr_data = '0;
        check("R6 event wins", 32'(rd_data[3]), 32'h1);
        write_reg(16'h0008);
        check("R6 later clear", 32'(rd_data[3]), 32'h0);
    endtask

    task automatic t_enables;
        write_reg(16'hFFF0);
        check("R8 enables", 32'(rd_data[11:8]), 32'hF);
        check("R8 unused zero", 32'(rd_data[15:12]), 32'h0);
        check("R8 gap zero", 32'(rd_data[7:5]), 32'h0);
        write_reg(16'h0000);
        check("R8 cleared", 32'(rd_data[11:8]), 32'h0);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_lps();
        t_sci_status();
        t_sci_irq();
        t_events();
        t_coincide();
        t_enables();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule